// File: doc/BRIEF.md
# Windowed Register File with Overlapping Call Frames

This block is the integer register file of a small RISC core whose procedure calls do not save registers to memory. The core names registers by a 5-bit virtual specifier. The block turns each specifier into a physical index using the current call depth. The low ten specifiers are shared by every procedure. The rest form a window that slides by sixteen entries per call level. The top six registers of a caller's window are the same storage as the bottom six of its callee's window. Arguments and return linkage therefore pass between levels without any copying.

The core reads two operands and writes one result per cycle, all by virtual specifier. It raises a call strobe to push the window one level deeper and a return strobe to pop it. A write presented in the same cycle as a call is mapped through the caller's window. This lets a call instruction deposit its return linkage in a register that the callee then sees at a lower specifier. When a call would need a window past the end of the physical file, the block raises a one-cycle overflow pulse. When a return would need a window below level zero, it raises a one-cycle underflow pulse. In both cases the depth stays where it was and that cycle's write is dropped. Spilling and refilling windows is left to the trap logic of the surrounding core.

Top module: `rwf_regfile`

## Requirements
- R1: Specifier 0 always reads as zero on both read ports, and a write to specifier 0 leaves its read value at zero.
- R2: Specifiers 1 to 9 name the same physical registers at every call depth.
- R3: Specifiers 10 to 31 address physical index (specifier + 16 × depth). For example, specifier 12 at depth 2 and specifier 28 at depth 1 both reach index 44.
- R4: A caller's specifiers 26 to 31 are the callee's specifiers 10 to 15.
- R5: A call strobe alone raises `win_depth` by one and a return strobe alone lowers it by one, taking effect after the clock edge. A call at depth 6 therefore gives depth 7.
- R6: A call at depth 7 (the last window) sets `ovf_o` high for exactly the following cycle, leaves `win_depth` unchanged and drops the write presented in that cycle.
- R7: A return at depth 0 sets `unf_o` high for exactly the following cycle, leaves `win_depth` unchanged and drops the write presented in that cycle.
- R8: A read of the physical register being written in the same cycle returns the new write data.
- R9: A write presented together with a call uses the caller's window. A value written as specifier 28 in that cycle reads back as specifier 12 after the call.
- R10: Synchronous reset sets `win_depth` to 0 and clears `ovf_o` and `unf_o`.
- R11: Call and return strobes asserted together leave `win_depth` unchanged and raise neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 5 | Virtual specifier, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_sel | input | 5 | Virtual specifier, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Virtual specifier for the write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Push the window one level |
| ret_i | input | 1 | Pop the window one level |
| win_depth | output | 3 | Current call depth |
| ovf_o | output | 1 | One-cycle window overflow pulse |
| unf_o | output | 1 | One-cycle window underflow pulse |

## Verification
Two things can land in the same cycle: a write and a window move. The bench drives both together. A call carries a write to specifier 28, and the value is expected to appear as specifier 12 one level deeper. A call at the last window and a return at level zero each carry a write. Reading the target afterwards must give its earlier contents, because a window fault drops that cycle's write. Write-to-read forwarding is also provoked: a read is presented on the register being written in the same cycle, and the read data is compared before the clock edge.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

   // Window movement requested in one cycle
   typedef enum logic [1:0] {
      WIN_HOLD  = 2'd0,
      WIN_PUSH  = 2'd1,
      WIN_POP   = 2'd2,
      WIN_FAULT = 2'd3
   } win_move_e;

   // Physical entries needed for a given geometry
   function automatic int phys_entries(input int glob_n, input int stride,
                                       input int win_n, input int ovl_n);
      return glob_n + win_n * stride + ovl_n;
   endfunction

endpackage

// File: rtl/rwf_map.sv
// Virtual-to-physical specifier translation for one port
module rwf_map #(
   parameter int SEL_W  = 5,
   parameter int DEP_W  = 3,
   parameter int PW     = 8,
   parameter int GLOB_N = 10,
   parameter int STRIDE = 16
) (
   input  logic [SEL_W-1:0] vsel,
   input  logic [DEP_W-1:0] depth,
   output logic [PW-1:0]    psel
);
   localparam int  SHIFT  = $clog2(STRIDE);
   localparam bit  POW2   = ((STRIDE & (STRIDE - 1)) == 0);

   logic            is_glob;
   logic [PW-1:0]   base;

   assign is_glob = (int'(vsel) < GLOB_N);

   generate
      if (POW2) begin : g_shift
         assign base = PW'(depth) << SHIFT;
      end else begin : g_mult
         assign base = PW'(depth) * PW'(STRIDE);
      end
   endgenerate

   assign psel = is_glob ? PW'(vsel) : (PW'(vsel) + base);

endmodule

// File: rtl/rwf_depth.sv
// Call-depth counter with overflow / underflow detection
module rwf_depth
   import rwf_pkg::*;
#(
   parameter int WIN_N = 8,
   parameter int DEP_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             call_i,
   input  logic             ret_i,
   output logic [DEP_W-1:0] depth,
   output logic             fault_now,
   output logic             ovf_q,
   output logic             unf_q
);
   localparam logic [DEP_W-1:0] MAXD = DEP_W'(WIN_N - 1);

   logic      ovf_now;
   logic      unf_now;
   win_move_e move;

   assign ovf_now   = call_i & ~ret_i & (depth == MAXD);
   assign unf_now   = ret_i & ~call_i & (depth == '0);
   assign fault_now = ovf_now | unf_now;

   always_comb begin
      if (fault_now)              move = WIN_FAULT;
      else if (call_i && !ret_i)  move = WIN_PUSH;
      else if (ret_i && !call_i)  move = WIN_POP;
      else                        move = WIN_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         depth <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ovf_q <= ovf_now;
         unf_q <= unf_now;
         case (move)
            WIN_PUSH: depth <= depth + 1'b1;
            WIN_POP:  depth <= depth - 1'b1;
            default:  depth <= depth;
         endcase
      end
   end

endmodule

// File: rtl/rwf_store.sv
// Physical storage: one synchronous write, NRD combinational reads with forwarding
module rwf_store #(
   parameter int DATA_W = 32,
   parameter int PHYS_N = 144,
   parameter int PW     = 8,
   parameter int NRD    = 2
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PW-1:0]     raddr [NRD],
   output logic [DATA_W-1:0] rdata [NRD]
);
   logic [DATA_W-1:0] mem [PHYS_N];

   always_ff @(posedge clk) begin
      if (we && waddr != '0) mem[waddr] <= wdata;
   end

   generate
      for (genvar p = 0; p < NRD; p++) begin : g_rd
         always_comb begin
            if (raddr[p] == '0)
               rdata[p] = '0;
            else if (we && waddr == raddr[p])
               rdata[p] = wdata;
            else
               rdata[p] = mem[raddr[p]];
         end
      end
   endgenerate

endmodule

// File: rtl/rwf_regfile.sv
module rwf_regfile
   import rwf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int VREG_N = 32,
   parameter int GLOB_N = 10,
   parameter int STRIDE = 16,
   parameter int WIN_N  = 8,
   parameter int OVL_N  = 6,
   localparam int SEL_W = $clog2(VREG_N),
   localparam int DEP_W = $clog2(WIN_N)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  rd_a_sel,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [SEL_W-1:0]  rd_b_sel,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              call_i,
   input  logic              ret_i,
   output logic [DEP_W-1:0]  win_depth,
   output logic              ovf_o,
   output logic              unf_o
);
   localparam int PHYS_N = phys_entries(GLOB_N, STRIDE, WIN_N, OVL_N);
   localparam int PW     = $clog2(PHYS_N);
   localparam int NPORT  = 3;   // read A, read B, write

   generate
      if (VREG_N != GLOB_N + STRIDE + OVL_N) begin : g_bad_geom
         $error("window geometry: VREG_N must equal GLOB_N + STRIDE + OVL_N");
      end
      if ((1 << DEP_W) != WIN_N) begin : g_bad_win
         $error("WIN_N must be a power of two");
      end
      if (OVL_N <= 0 || OVL_N >= STRIDE) begin : g_bad_ovl
         $error("OVL_N must lie between 1 and STRIDE-1");
      end
   endgenerate

   logic [SEL_W-1:0]  vsel  [NPORT];
   logic [PW-1:0]     psel  [NPORT];
   logic [PW-1:0]     raddr [2];
   logic [DATA_W-1:0] rdata [2];
   logic              fault_now;
   logic              we_eff;

   assign vsel[0] = rd_a_sel;
   assign vsel[1] = rd_b_sel;
   assign vsel[2] = wr_sel;

   rwf_depth #(.WIN_N(WIN_N), .DEP_W(DEP_W)) u_depth (
      .clk       (clk),
      .rst       (rst),
      .call_i    (call_i),
      .ret_i     (ret_i),
      .depth     (win_depth),
      .fault_now (fault_now),
      .ovf_q     (ovf_o),
      .unf_q     (unf_o)
   );

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_map
         rwf_map #(
            .SEL_W(SEL_W), .DEP_W(DEP_W), .PW(PW),
            .GLOB_N(GLOB_N), .STRIDE(STRIDE)
         ) u_map (
            .vsel  (vsel[i]),
            .depth (win_depth),
            .psel  (psel[i])
         );
      end
   endgenerate

   assign we_eff   = wr_en & ~fault_now;
   assign raddr[0] = psel[0];
   assign raddr[1] = psel[1];

   rwf_store #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .PW(PW), .NRD(2)) u_store (
      .clk   (clk),
      .we    (we_eff),
      .waddr (psel[2]),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (rdata)
   );

   assign rd_a_data = rdata[0];
   assign rd_b_data = rdata[1];

endmodule

// File: rtl/rwf_regfile_chk.sv
module rwf_regfile_chk #(
   parameter int WIN_N  = 8,
   parameter int SEL_W  = 5,
   parameter int DATA_W = 32,
   localparam int DEP_W = $clog2(WIN_N)
) (
   input logic              clk,
   input logic              rst,
   input logic              call_i,
   input logic              ret_i,
   input logic [DEP_W-1:0]  win_depth,
   input logic              ovf_o,
   input logic              unf_o,
   input logic [SEL_W-1:0]  rd_b_sel,
   input logic [DATA_W-1:0] rd_b_data
);
   localparam logic [DEP_W-1:0] MAXD = DEP_W'(WIN_N - 1);

   // R5
   call_step_chk: assert property (@(posedge clk) disable iff (rst)
      (call_i && !ret_i && win_depth != MAXD) |=> win_depth == $past(win_depth) + 1'b1);

   // R5
   ret_step_chk: assert property (@(posedge clk) disable iff (rst)
      (ret_i && !call_i && win_depth != '0) |=> win_depth == $past(win_depth) - 1'b1);

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (call_i && !ret_i && win_depth == MAXD) |=> (ovf_o && $stable(win_depth)));

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      (ret_i && !call_i && win_depth == '0) |=> (unf_o && $stable(win_depth)));

   // R11
   both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (call_i && ret_i) |=> ($stable(win_depth) && !ovf_o && !unf_o));

   // R6
   flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ovf_o, unf_o}));

   // R1
   zero_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_b_sel == '0) |-> rd_b_data == '0);

endmodule

bind rwf_regfile rwf_regfile_chk #(.WIN_N(WIN_N), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .call_i    (call_i),
   .ret_i     (ret_i),
   .win_depth (win_depth),
   .ovf_o     (ovf_o),
   .unf_o     (unf_o),
   .rd_b_sel  (rd_b_sel),
   .rd_b_data (rd_b_data)
);

// File: tb/rwf_regfile_bench.sv
module rwf_regfile_bench;

   typedef enum int {K_RDA, K_RDB, K_DEPTH, K_OVF, K_UNF} kind_e;
   typedef struct {
      kind_e       kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
   logic [2:0]  win_depth;
   logic        ovf_o, unf_o;

   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   item_t sb [$];

   always #4 clk = ~clk;   // 125 MHz

   rwf_regfile u_rwf_regfile (
      .clk(clk), .rst(rst),
      .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
      .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .call_i(call_i), .ret_i(ret_i),
      .win_depth(win_depth), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_item(kind_e k, logic [31:0] v, string tag);
      item_t it;
      it.kind = k; it.exp = v; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle();
      wr_en = 1'b0; call_i = 1'b0; ret_i = 1'b0;
   endtask

   task automatic wr(logic [4:0] s, logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      tick();
      idle();
   endtask

   task automatic rd_a(logic [4:0] s, logic [31:0] v, string tag);
      rd_a_sel = s;
      expect_item(K_RDA, v, tag);
      tick();
   endtask

   // monitor: compare every queued item in the middle of the cycle
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         case (it.kind)
            K_RDA:   act = rd_a_data;
            K_RDB:   act = rd_b_data;
            K_DEPTH: act = {29'd0, win_depth};
            K_OVF:   act = {31'd0, ovf_o};
            default: act = {31'd0, unf_o};
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst = 1'b0;
      // R10 reset state
      expect_item(K_DEPTH, 0, "R10 depth");
      expect_item(K_OVF, 0, "R10 ovf");
      expect_item(K_UNF, 0, "R10 unf");
      tick();

      // R8 forwarding: read B targets the register being written
      wr_en = 1'b1; wr_sel = 5'd5; wr_data = 32'hA5A5_0005;
      rd_b_sel = 5'd5;
      expect_item(K_RDB, 32'hA5A5_0005, "R8 forward");
      tick();
      idle();
      wr(5'd9, 32'h0000_0099);

      // R1 write to r0 has no visible effect
      wr(5'd0, 32'hFFFF_FFFF);
      rd_a(5'd0, 32'h0, "R1 r0 port A");
      rd_b_sel = 5'd0;
      expect_item(K_RDB, 32'h0, "R1 r0 port B");
      tick();

      // outgoing arguments, then call carrying the linkage write (R9)
      wr(5'd26, 32'h0000_0011);
      wr(5'd27, 32'h0000_0022);
      call_i = 1'b1; wr_en = 1'b1; wr_sel = 5'd28; wr_data = 32'h0000_0208;
      tick();
      idle();
      expect_item(K_DEPTH, 1, "R5 call increments");
      tick();
      rd_a(5'd10, 32'h0000_0011, "R4 r26 as r10");
      rd_a(5'd11, 32'h0000_0022, "R4 r27 as r11");
      rd_a(5'd12, 32'h0000_0208, "R9 linkage as r12");
      rd_a(5'd5,  32'hA5A5_0005, "R2 global at depth 1");

      // R3 index arithmetic across levels
      wr(5'd20, 32'h0000_0077);
      call_i = 1'b1; tick(); idle();
      expect_item(K_DEPTH, 2, "R5 depth 2");
      wr(5'd12, 32'h0000_4444);
      ret_i = 1'b1; tick(); idle();
      expect_item(K_DEPTH, 1, "R5 return decrements");
      rd_a(5'd28, 32'h0000_4444, "R3 r12@2 == r28@1");
      rd_a(5'd20, 32'h0000_0077, "R3 local kept");

      // climb to the last window
      for (int k = 0; k < 6; k++) begin
         call_i = 1'b1; tick(); idle();
      end
      expect_item(K_DEPTH, 7, "R5 depth 7");
      wr(5'd15, 32'h0000_1234);

      // R11 simultaneous strobes at the last window
      call_i = 1'b1; ret_i = 1'b1; tick(); idle();
      expect_item(K_DEPTH, 7, "R11 depth held");
      expect_item(K_OVF, 0, "R11 no ovf");
      expect_item(K_UNF, 0, "R11 no unf");
      tick();

      // R6 overflow with a write in the same cycle
      call_i = 1'b1; wr_en = 1'b1; wr_sel = 5'd15; wr_data = 32'hDEAD_BEEF;
      tick();
      idle();
      expect_item(K_OVF, 1, "R6 ovf pulse");
      expect_item(K_DEPTH, 7, "R6 depth held");
      rd_a(5'd15, 32'h0000_1234, "R6 write dropped");
      expect_item(K_OVF, 0, "R6 pulse one cycle");
      tick();

      // unwind to level 0
      for (int k = 0; k < 7; k++) begin
         ret_i = 1'b1; tick(); idle();
      end
      expect_item(K_DEPTH, 0, "R5 back to 0");
      rd_a(5'd9, 32'h0000_0099, "R2 global at depth 0");

      // R7 underflow with a write in the same cycle
      ret_i = 1'b1; wr_en = 1'b1; wr_sel = 5'd9; wr_data = 32'h0000_0055;
      tick();
      idle();
      expect_item(K_UNF, 1, "R7 unf pulse");
      expect_item(K_DEPTH, 0, "R7 depth held");
      rd_a(5'd9, 32'h0000_0099, "R7 write dropped");
      expect_item(K_UNF, 0, "R7 pulse one cycle");
      tick();
      tick();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule